// File: doc/BRIEF.md
# Microcoded Control Sequencer with Early Step Clear

This block drives the microcode lookup for a small accumulator computer. It keeps a micro-step counter and, for each of three identical microcode banks, forms a 15-bit lookup address. Each address combines the instruction opcode, the ALU carry and zero flags, the bank's own index and the current step. It returns the 8-bit word each bank holds at that address. A dedicated bit of one bank's word acts as an active-high step clear. An instruction raises it on its last step to end early. An instruction that never raises it runs all eight steps and the counter wraps on its own.

The microcode store is inside the block. It is filled through a small write port while the sequencer is held in reset. The counter moves on the falling clock edge, so every word is settled before the datapath samples on the rising edge. The current step is an output for a step display.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst` is high the step output is 0. The step clears at once when `rst` rises, without waiting for a clock edge.
- R2: The address of bank b (b = 0, 1, 2) is laid out as follows. Step is bits [2:0] and b is bits [4:3]. Carry is bit 5 and zero is bit 6. Bits [8:7] are 0. The 4-bit opcode is bits [12:9] and bits [14:13] are 0.
- R3: The data output of each bank equals the word last loaded at that bank's current address. It follows address changes combinationally.
- R4: With `rst` low, the step goes up by one on each falling clock edge. This holds while the step clear is low and the step is below 7.
- R5: On the falling edge after step 7, the step returns to 0 whether or not the step clear is asserted.
- R6: Bit 7 of bank 2's data word is the step clear. When it is high at step k, the next step is 0 instead of k+1. This covers k = 0, which holds the step at 0.
- R7: A load-port write takes effect on the rising clock edge only while `rst` is high. A write made with `rst` low leaves the stored contents unchanged.
- R8: A load-port write is dropped when its address cannot be reached by any read. That is the case when bits [14:13] are non-zero, bits [8:7] are non-zero, or bits [4:3] equal 3. Such a write does not alter any reachable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the step moves on its falling edge, loads commit on its rising edge |
| rst | input | 1 | Active-high asynchronous reset; also enables loading |
| opcode | input | 4 | Instruction opcode from the instruction register |
| carry | input | 1 | ALU carry flag |
| zero | input | 1 | ALU zero flag |
| ld_we | input | 1 | Load-port write enable |
| ld_addr | input | 15 | Load-port address, same layout as R2 |
| ld_data | input | 8 | Load-port data word |
| bank_addr | output | 45 | Three 15-bit bank addresses, bank 0 in the low bits |
| bank_data | output | 24 | Three 8-bit bank words, bank 0 in the low bits |
| step | output | 3 | Current micro-step |

## Verification
The bench fills every reachable word with a pattern. In that pattern the step-clear position depends on the opcode, and for one opcode also on the carry flag. This produces instructions of every length from one to eight steps. A counter that ignored the clear would run past the last step. One that cleared a cycle late would show step k+1 before 0. One that failed to wrap would stall or overflow at step 7.

The bench also writes with reset low, and writes to addresses with reserved bits set or with bank 3. A store that accepted those writes, or folded away the reserved bits, would return the wrong word later. Reset is also raised in the middle of an instruction to confirm the step clears without waiting for an edge.

// File: rtl/useq_pkg.sv
package useq_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int OPC_W    = 6;
  localparam int OPC_USED = 4;
  localparam int FLG_W    = 4;
  localparam int FLG_USED = 2;
  localparam int BSEL_W   = 2;
  localparam int STEP_W   = 3;
  localparam int DATA_W   = 8;
  localparam int N_BANKS  = 3;

  localparam int STEP_LSB = 0;
  localparam int BSEL_LSB = STEP_LSB + STEP_W;
  localparam int FLG_LSB  = BSEL_LSB + BSEL_W;
  localparam int OPC_LSB  = FLG_LSB + FLG_W;
  localparam int ADDR_W   = OPC_LSB + OPC_W;
  localparam int IDX_W    = OPC_USED + FLG_USED + BSEL_W + STEP_W;

  function automatic logic [ADDR_W-1:0] pack_addr(
    input logic [OPC_USED-1:0] opc,
    input logic [FLG_USED-1:0] flg,
    input logic [BSEL_W-1:0]   bsel,
    input logic [STEP_W-1:0]   stp);
    pack_addr = {{(OPC_W-OPC_USED){1'b0}}, opc,
                 {(FLG_W-FLG_USED){1'b0}}, flg, bsel, stp};
  endfunction

  function automatic logic addr_reachable(input logic [ADDR_W-1:0] a);
    logic hi_opc_clr, hi_flg_clr, bank_ok;
    hi_opc_clr = (a[ADDR_W-1 -: (OPC_W-OPC_USED)] == '0);
    hi_flg_clr = (a[FLG_LSB+FLG_USED +: (FLG_W-FLG_USED)] == '0);
    bank_ok    = (a[BSEL_LSB +: BSEL_W] < BSEL_W'(N_BANKS));
    addr_reachable = hi_opc_clr & hi_flg_clr & bank_ok;
  endfunction

  function automatic logic [IDX_W-1:0] store_index(input logic [ADDR_W-1:0] a);
    store_index = {a[OPC_LSB +: OPC_USED], a[FLG_LSB +: FLG_USED],
                   a[BSEL_LSB +: BSEL_W], a[STEP_LSB +: STEP_W]};
  endfunction
endpackage

// File: rtl/useq_step_counter.sv
module useq_step_counter #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_clr,
  output logic [STEP_W-1:0] step,
  output logic              wrap_evt,
  output logic              early_evt
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [STEP_W-1:0] STEP_LAST = '1;

  logic [STEP_W-1:0] cnt_q;
  logic [STEP_W:0]   cnt_inc;
  logic              clr_any;

  assign cnt_inc   = {1'b0, cnt_q} + (STEP_W+1)'(1);
  assign wrap_evt  = cnt_inc[STEP_W];
  assign early_evt = step_clr & ~wrap_evt;
  assign clr_any   = wrap_evt | step_clr;

  always_ff @(negedge clk or posedge rst) begin
    if (rst)          cnt_q <= '0;
    else if (clr_any) cnt_q <= '0;
    else              cnt_q <= cnt_inc[STEP_W-1:0];
  end

  assign step = cnt_q;

  // R4
  step_adv_chk: assert property (@(negedge clk) disable iff (rst)
    (!step_clr && step != STEP_LAST) |=> step == $past(step) + STEP_W'(1));
  // R5
  step_wrap_chk: assert property (@(negedge clk) disable iff (rst)
    (step == STEP_LAST) |=> step == '0);
  // R6
  early_clr_chk: assert property (@(negedge clk) disable iff (rst)
    early_evt |=> step == '0);
endmodule

// File: rtl/useq_addr_pack.sv
module useq_addr_pack import useq_pkg::*; #(
  parameter int BANK = 0
) (
  input  logic [OPC_USED-1:0] opcode,
  input  logic                carry,
  input  logic                zero,
  input  logic [STEP_W-1:0]   step,
  output logic [ADDR_W-1:0]   addr
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [BSEL_W-1:0] BSEL = BSEL_W'(BANK);

  assign addr = pack_addr(opcode, {zero, carry}, BSEL, step);
endmodule

// File: rtl/useq_ucode_store.sv
module useq_ucode_store import useq_pkg::*; #(
  parameter int N_RD = 3
) (
  input  logic                     clk,
  input  logic                     load_mode,
  input  logic                     ld_we,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic [DATA_W-1:0]        ld_data,
  input  logic [N_RD*ADDR_W-1:0]   rd_addr,
  output logic [N_RD*DATA_W-1:0]   rd_data
);
  timeunit 1ns; timeprecision 1ps;

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_commit;
  logic              was_load_q;

  assign wr_commit = ld_we & load_mode & addr_reachable(ld_addr);

  always_ff @(posedge clk) begin
    if (wr_commit) mem[store_index(ld_addr)] <= ld_data;
  end

  always_ff @(posedge clk) was_load_q <= load_mode;

  for (genvar b = 0; b < N_RD; b++) begin : g_rd
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_word;
    assign rd_idx  = store_index(rd_addr[b*ADDR_W +: ADDR_W]);
    assign rd_word = mem[rd_idx];
    assign rd_data[b*DATA_W +: DATA_W] = rd_word;

    // R7
    frozen_store_chk: assert property (@(posedge clk)
      disable iff (load_mode || was_load_q)
      $stable(rd_idx) |-> $stable(rd_word));
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer import useq_pkg::*; #(
  parameter int CLR_BANK = 2,
  parameter int CLR_BIT  = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [OPC_USED-1:0]         opcode,
  input  logic                        carry,
  input  logic                        zero,
  input  logic                        ld_we,
  input  logic [ADDR_W-1:0]           ld_addr,
  input  logic [DATA_W-1:0]           ld_data,
  output logic [N_BANKS*ADDR_W-1:0]   bank_addr,
  output logic [N_BANKS*DATA_W-1:0]   bank_data,
  output logic [STEP_W-1:0]           step
);
  timeunit 1ns; timeprecision 1ps;

  localparam int CLR_POS = CLR_BANK*DATA_W + CLR_BIT;

  logic step_clr;
  logic wrap_evt;
  logic early_evt;

  assign step_clr = bank_data[CLR_POS];

  useq_step_counter #(.STEP_W(STEP_W)) u_step (
    .clk(clk), .rst(rst), .step_clr(step_clr),
    .step(step), .wrap_evt(wrap_evt), .early_evt(early_evt)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    useq_addr_pack #(.BANK(b)) u_pack (
      .opcode(opcode), .carry(carry), .zero(zero), .step(step),
      .addr(bank_addr[b*ADDR_W +: ADDR_W])
    );

    // R2
    addr_field_chk: assert property (@(posedge clk) disable iff (rst)
      bank_addr[b*ADDR_W + STEP_LSB +: STEP_W] == step &&
      bank_addr[b*ADDR_W + BSEL_LSB +: BSEL_W] == BSEL_W'(b) &&
      bank_addr[b*ADDR_W + OPC_LSB +: OPC_USED] == opcode);
  end

  useq_ucode_store #(.N_RD(N_BANKS)) u_store (
    .clk(clk), .load_mode(rst), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_addr(bank_addr), .rd_data(bank_data)
  );

  // R1
  reset_hold_chk: assert property (@(posedge clk) rst |-> step == '0);
  // R5
  wrap_zero_chk: assert property (@(negedge clk) disable iff (rst)
    wrap_evt |=> step == '0);
endmodule

// File: tb/ucode_sequencer_bench.sv
module ucode_sequencer_bench;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = '0;
  logic        carry = 1'b0, zero = 1'b0, ld_we = 1'b0;
  logic [14:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [44:0] bank_addr;
  logic [23:0] bank_data;
  logic [2:0]  step;

  ucode_sequencer u_ucode_sequencer (
    .clk(clk), .rst(rst), .opcode(opcode), .carry(carry), .zero(zero),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .bank_addr(bank_addr), .bank_data(bank_data), .step(step)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, m_step = 0;
  int unsigned ref_mem [int];
  bit finished = 0;

  function automatic int addr_of(int opc, int c, int z, int b, int s);
    return opc*512 + z*64 + c*32 + b*8 + s;
  endfunction

  function automatic int pat(int opc, int f, int b, int s);
    int len, lo;
    lo  = (opc*13 + f*7 + b*29 + s*3 + 1) % 128;
    len = (opc == 9 && (f % 2) == 1) ? 2 : opc % 8;
    if (b == 2) return lo + ((s == len) ? 128 : 0);
    return lo + ((s % 2) * 128);
  endfunction

  function automatic int rd(int a);
    return ref_mem.exists(a) ? int'(ref_mem[a]) : 0;
  endfunction

  function automatic bit reachable(int a);
    return (a / 8192) == 0 && ((a / 128) % 4) == 0 && ((a / 8) % 4) != 3;
  endfunction

  always @(negedge clk) begin
    if (rst) m_step = 0;
    else if (m_step == 7 || rd(addr_of(opcode, carry, zero, 2, m_step)) >= 128) m_step = 0;
    else m_step = m_step + 1;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, int'(step), m_step);
    for (int b = 0; b < 3; b++) begin
      int a;
      a = addr_of(opcode, carry, zero, b, m_step);
      chk("R2", int'(bank_addr[b*15 +: 15]), a);
      chk({"R3/", tag}, int'(bank_data[b*8 +: 8]), rd(a));
    end
  endtask

  task automatic cyc(string tag);
    @(negedge clk); #1;
    compare(tag);
  endtask

  task automatic load(int a, int d, string tag);
    ld_addr = 15'(a); ld_data = 8'(d); ld_we = 1'b1;
    @(posedge clk);
    if (rst && reachable(a)) ref_mem[a] = d;
    cyc(tag);
    ld_we = 1'b0;
  endtask

  task automatic run(int opc, int c, int z, int n, string tag);
    opcode = 4'(opc); carry = c[0]; zero = z[0];
    repeat (n) cyc(tag);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: step held at 0 while the store is filled
    for (int o = 0; o < 16; o++)
      for (int f = 0; f < 4; f++)
        for (int b = 0; b < 3; b++)
          for (int s = 0; s < 8; s++)
            load(addr_of(o, f % 2, f / 2, b, s), pat(o, f, b, s), "R1");
    // R8: unreachable writes must not alias onto reachable words
    load(addr_of(5, 0, 0, 0, 1) + 8192, 8'h5A, "R8");
    load(addr_of(5, 0, 0, 0, 2) + 128,  8'hA5, "R8");
    load(addr_of(5, 0, 0, 3, 3),        8'h3C, "R8");
    load(addr_of(5, 0, 0, 2, 0) + 16384, 8'h80, "R8");
    rst = 1'b0;
    run(5, 0, 0, 12, "R8");
    run(3, 1, 0, 10, "R4");
    run(7, 0, 1, 20, "R5");
    run(2, 0, 0, 9,  "R6");
    run(0, 1, 1, 4,  "R6");
    run(9, 1, 0, 9,  "R6");
    run(9, 0, 0, 10, "R6");
    run(15, 1, 1, 18, "R5");
    for (int o = 0; o < 16; o++) run(o, o % 2, (o / 2) % 2, 9, "R4");
    // R7: write with reset low is ignored
    load(addr_of(7, 0, 0, 0, 3), 8'hFF, "R7");
    load(addr_of(7, 0, 0, 2, 2), 8'h80, "R7");
    run(7, 0, 0, 18, "R7");
    // R1: reset raised mid-instruction clears the step without an edge
    run(6, 0, 0, 3, "R4");
    @(posedge clk); #1;
    rst = 1'b1; #0.5;
    chk("R1", int'(step), 0);
    cyc("R1");
    rst = 1'b0;
    run(4, 0, 1, 8, "R4");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule